// File: doc/BRIEF.md
# MDIO management master

This block is a register-mapped master for the two-wire PHY management bus. It produces the management clock MDC and drives or releases the bidirectional MDIO line. Software first loads a 16-bit address register and a 16-bit write-data register. It then writes one command word. That word carries the two-bit start-of-frame code, the two-bit opcode, the 5-bit port address, the 5-bit device or register address and a start bit. The controller builds a complete 64-bit management frame from these values and shifts it out. It captures the 16 read-data bits for read frames.

The start-of-frame and opcode fields go onto the wire exactly as software gives them. One engine therefore serves both the short-form frames (code 1: write 1, read 2) and the extended frames (code 0: address 0, write 1, read with post-increment 2, read 3). Multi-frame extended sequences are built by software, one command after another. Software polls the start bit, which stays set while a frame is in progress. After a read it checks the failure flag before it uses the read data.

The register interface is a plain single-cycle register port: writes take effect at the clock edge and reads are combinational. The interface has no stream data path, so it has no valid/ready handshake and no back-pressure.

Top module: `mdio_master`

## Requirements
- R1: Register words are decoded from reg_addr[4:2]: 0 command, 1 address, 2 write data, 3 read data, 4 status. The command word reads back as the stored fields in bits [13:0] and the busy flag in bit 14. The stored fields are: device/register address in [4:0], port address in [9:5], opcode in [11:10] and start-of-frame code in [13:12]. The address and write-data words read back their low 16 bits, and all bits that hold no field read 0. After reset every register reads 0.
- R2: A command write with bit 14 set while idle starts a frame. Bit 14 then reads 1 for exactly 128*HALF_DIV clock cycles, counted from the write edge, and 0 afterwards.
- R3: Each frame is sent MSB first on MDC rising edges in this order: 32 ones, start code, opcode, port address, device/register address, a 2-bit turnaround and 16 data bits. The start code and opcode go out exactly as stored.
- R4: A write frame (opcode bit 1 = 0) drives the turnaround as 1 then 0. Its data field is the address register when the start code and opcode are both 0, and the write-data register otherwise.
- R5: A frame whose opcode bit 1 is 1 is a read. mdio_oe stays high through the first turnaround bit (driven 1) and is low from the second turnaround bit to the end of the frame. The 16 data bits are sampled on MDC rising edges and are presented in read data, MSB first.
- R6: Status bit 0 becomes 1 after a read in which MDIO was sampled high on the second turnaround bit, and 0 after a read in which it was low.
- R7: MDC is low when idle and has half periods of HALF_DIV clock cycles. mdio_o changes only together with an MDC falling edge.
- R8: A command-register write while bit 14 reads 1 is ignored. The frame in progress and the stored command fields are unchanged.
- R9: Status and read data change only when a read frame completes. Write and address frames leave them as they were.
- R10: Between frames mdio_oe is 0 and MDC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable, 1 = master drives |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench builds the block with HALF_DIV = 2, so one frame lasts 256 clock cycles. This keeps the frame length exact to check by counting, and lets every opcode of both frame types run, together with a failed read, an ignored mid-frame command and the status-hold sequence, all well inside the cycle budget. A small PHY model drives the turnaround and data bits from a response vector. With HALF_DIV = 2 the MDC period is short enough to be measured directly between rising edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA2_IDX    = 47;
  localparam int DAT0_IDX   = 48;
  localparam int CMD_W      = 14;

  typedef struct packed {
    logic [1:0] sof;
    logic [1:0] op;
    logic [4:0] port;
    logic [4:0] dev;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap    = run && (cnt_q == LAST);
  assign rise_tk = wrap && !mdc_q;
  assign fall_tk = wrap && mdc_q;
  assign mdc     = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] payload,
  input  logic        rise_tk,
  input  logic        fall_tk,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done_rd,
  output logic        rd_fail,
  output logic [15:0] rd_data
);
  localparam logic [BIT_W-1:0] LAST_B = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TA2_B  = BIT_W'(TA2_IDX);
  localparam logic [BIT_W-1:0] DAT0_B = BIT_W'(DAT0_IDX);

  logic [FRAME_BITS-1:0] shift_q;
  logic [BIT_W-1:0]      bit_q;
  logic                  busy_q, rd_q, fail_q;
  logic [15:0]           cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '1;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      fail_q  <= 1'b0;
      cap_q   <= '0;
    end else if (start) begin
      shift_q <= {32'hFFFF_FFFF, cmd.sof, cmd.op, cmd.port, cmd.dev, 2'b10, payload};
      bit_q   <= '0;
      busy_q  <= 1'b1;
      rd_q    <= cmd.op[1];
    end else if (busy_q) begin
      if (rise_tk) begin
        if (bit_q == TA2_B) fail_q <= mdio_i;
        if (bit_q >= DAT0_B) cap_q <= {cap_q[14:0], mdio_i};
      end
      if (fall_tk) begin
        if (bit_q == LAST_B) begin
          busy_q <= 1'b0;
        end else begin
          shift_q <= {shift_q[FRAME_BITS-2:0], 1'b1};
          bit_q   <= bit_q + 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = busy_q ? shift_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && (bit_q >= TA2_B));
  assign done_rd = busy_q && fall_tk && (bit_q == LAST_B) && rd_q;
  assign rd_fail = fail_q;
  assign rd_data = cap_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [2:0] W_CMD  = 3'd0;
  localparam logic [2:0] W_ADDR = 3'd1;
  localparam logic [2:0] W_WDAT = 3'd2;
  localparam logic [2:0] W_RDAT = 3'd3;
  localparam logic [2:0] W_STAT = 3'd4;

  mdio_cmd_t   cmd_q, cmd_new;
  logic [15:0] addr_q, wdat_q, rdat_q, payload, rd_data;
  logic        stat_q, busy, cmd_wr, start, done_rd, rd_fail;
  logic        rise_tk, fall_tk;
  logic [2:0]  word;
  logic        unused_bits;

  assign word        = reg_addr[4:2];
  assign unused_bits = ^{reg_wdata[31:15], reg_addr[1:0]};
  assign cmd_new     = mdio_cmd_t'(reg_wdata[CMD_W-1:0]);
  assign cmd_wr      = reg_we && (word == W_CMD);
  assign start       = cmd_wr && !busy && reg_wdata[CMD_W];
  assign payload     = (cmd_new.sof == 2'd0 && cmd_new.op == 2'd0) ? addr_q : wdat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      stat_q <= 1'b0;
    end else begin
      if (cmd_wr && !busy) cmd_q <= cmd_new;
      if (reg_we && word == W_ADDR) addr_q <= reg_wdata[15:0];
      if (reg_we && word == W_WDAT) wdat_q <= reg_wdata[15:0];
      if (done_rd) begin
        rdat_q <= rd_data;
        stat_q <= rd_fail;
      end
    end
  end

  always_comb begin
    case (word)
      W_CMD:   reg_rdata = {17'd0, busy, cmd_q};
      W_ADDR:  reg_rdata = {16'd0, addr_q};
      W_WDAT:  reg_rdata = {16'd0, wdat_q};
      W_RDAT:  reg_rdata = {16'd0, rdat_q};
      W_STAT:  reg_rdata = {31'd0, stat_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_new), .payload(payload),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done_rd(done_rd), .rd_fail(rd_fail), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        cmd_wr,
  input logic [13:0] cmd_q,
  input logic [15:0] rdat_q,
  input logic        stat_q
);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R8
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q));

  // R7
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

  // R5
  release_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> $fell(mdc));

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q) |-> $fell(busy));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdat_q) |-> $fell(busy));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .cmd_wr(cmd_wr), .cmd_q(cmd_q), .rdat_q(rdat_q),
  .stat_q(stat_q)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int HD = 2;
  localparam int FRAME_CYC = 128 * HD;

  typedef struct packed {
    logic [1:0]  sof;
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] addr;
    logic [15:0] wdat;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd1, 2'd1, 5'h03, 5'h11, 16'h5555, 16'hA5C3, 16'h0000},
    '{2'd1, 2'd2, 5'h1F, 5'h00, 16'h0000, 16'h0000, 16'h1234},
    '{2'd0, 2'd0, 5'h0A, 5'h07, 16'hBEEF, 16'h7777, 16'h0000},
    '{2'd0, 2'd1, 5'h0A, 5'h07, 16'h3333, 16'h0F0F, 16'h0000},
    '{2'd0, 2'd2, 5'h15, 5'h1E, 16'h0000, 16'h0000, 16'hCAFE},
    '{2'd0, 2'd3, 5'h01, 5'h02, 16'h0000, 16'h0000, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int fails = 0;
  logic [63:0] cap = '0, oecap = '0, resp = '1;
  int rises = 0, base = 0, cyc = 0, rise_cyc = 0, prev_rise_cyc = 0;

  mdio_master #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    cap           <= {cap[62:0], mdio_o};
    oecap         <= {oecap[62:0], mdio_oe};
    rises         <= rises + 1;
    rise_cyc      <= cyc;
    prev_rise_cyc <= rise_cyc;
  end

  assign mdio_i = ((rises - base) >= 0 && (rises - base) < 64) ? resp[63 - (rises - base)] : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    reg_addr = 5'h00;
    #1;
    while (reg_rdata[14]) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [63:0] make_resp(input logic [15:0] d, input bit ack);
    return {{47{1'b1}}, ~ack, d};
  endfunction

  task automatic issue(input vec_t v, input logic [63:0] r);
    wr(5'h04, {16'd0, v.addr});
    wr(5'h08, {16'd0, v.wdat});
    resp = r;
    base = rises;
    wr(5'h00, {17'd0, 1'b1, v.sof, v.op, v.port, v.dev});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    logic [63:0] exp, mask;
    logic [15:0] pay;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values; R10 idle pins
    rd(5'h00, d); chk(d == 0, "R1 reset cmd", d, 0);
    rd(5'h0C, d); chk(d == 0, "R1 reset rdata", d, 0);
    rd(5'h10, d); chk(d == 0, "R1 reset status", d, 0);
    chk(mdc == 0, "R10 reset mdc", mdc, 0);
    chk(mdio_oe == 0, "R10 reset oe", mdio_oe, 0);

    // R1 readback of low 16 bits
    wr(5'h04, 32'hFFFF_1234);
    rd(5'h04, d); chk(d == 32'h1234, "R1 addr readback", d, 32'h1234);
    wr(5'h08, 32'hABCD_9876);
    rd(5'h08, d); chk(d == 32'h9876, "R1 wdata readback", d, 32'h9876);

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      bit is_rd;
      v = VECS[i];
      is_rd = v.op[1];
      pay = is_rd ? 16'h0 : ((v.sof == 0 && v.op == 0) ? v.addr : v.wdat);
      exp = {32'hFFFF_FFFF, v.sof, v.op, v.port, v.dev, 2'b10, pay};
      mask = is_rd ? {{47{1'b1}}, 17'd0} : '1;
      issue(v, make_resp(v.data, 1'b1));
      wait_done(n);
      chk(n == FRAME_CYC, "R2 busy duration", n, FRAME_CYC);
      chk(((cap ^ exp) & mask) == 0, is_rd ? "R3 read frame bits" : "R4 write frame bits", cap & mask, exp & mask);
      chk(oecap == mask, "R5 output enable pattern", oecap, mask);
      if (is_rd) begin
        rd(5'h0C, d); chk(d == {16'd0, v.data}, "R5 read data", d, {16'd0, v.data});
        rd(5'h10, d); chk(d == 0, "R6 status after ack", d, 0);
      end
    end

    // R7 MDC period and idle level
    chk(rise_cyc - prev_rise_cyc == 2 * HD, "R7 mdc period", rise_cyc - prev_rise_cyc, 2 * HD);
    @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0, "R10 idle after frames", {mdc, mdio_oe}, 0);

    // R8 command write during a frame is ignored; R1 busy readback
    issue(VECS[0], '1);
    repeat (40) @(negedge clk);
    rd(5'h00, d);
    chk(d == {17'd0, 1'b1, 14'({2'd1, 2'd1, 5'h03, 5'h11})}, "R1 cmd readback busy", d, {17'd0, 1'b1, 14'({2'd1, 2'd1, 5'h03, 5'h11})});
    wr(5'h00, {17'd0, 1'b1, 2'd0, 2'd3, 5'h1C, 5'h0C});
    wait_done(n);
    exp = {32'hFFFF_FFFF, 2'd1, 2'd1, 5'h03, 5'h11, 2'b10, 16'hA5C3};
    chk(cap == exp, "R8 frame unchanged", cap, exp);
    rd(5'h00, d);
    chk(d == {18'd0, 14'({2'd1, 2'd1, 5'h03, 5'h11})}, "R8 fields unchanged", d, {18'd0, 14'({2'd1, 2'd1, 5'h03, 5'h11})});

    // R6 no acknowledge on turnaround
    issue(VECS[1], make_resp(16'h4321, 1'b0));
    wait_done(n);
    rd(5'h10, d); chk(d == 1, "R6 status on missing ack", d, 1);
    rd(5'h0C, d); chk(d == 32'h4321, "R5 data on failed read", d, 32'h4321);

    // R9 write frame leaves status and read data
    issue(VECS[3], '1);
    wait_done(n);
    rd(5'h10, d); chk(d == 1, "R9 status held", d, 1);
    rd(5'h0C, d); chk(d == 32'h4321, "R9 rdata held", d, 32'h4321);

    // R6 a good read clears status
    issue(VECS[5], make_resp(16'h00FF, 1'b1));
    wait_done(n);
    rd(5'h10, d); chk(d == 0, "R6 status cleared", d, 0);
    rd(5'h0C, d); chk(d == 32'h00FF, "R5 rdata new", d, 32'h00FF);

    // R10 idle again
    repeat (10) @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0, "R10 idle end", {mdc, mdio_oe}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule